// File: doc/BRIEF.md
# Timer with Selectable Trigger Output

This block is an up-counting timer for a larger chip. The system clock goes through a programmable divider. Each divided tick moves a counter one step, and the counter wraps to zero after it reaches a terminal value. Both the divider and the terminal value have a pending copy and an active copy. The pending copies move into the active copies on every update event. An update event is either a counter wrap or a software-forced update. The terminal value can also take effect at once when buffering is turned off.

A selector field picks one of eight internal sources to drive `trgo`. Other logic uses this registered signal to start conversions or to start other timers. The sources are:
- the forced update
- the run flag
- every update event
- a pulse when the counter reaches the first compare value
- one of four compare reference levels

Four compare channels supply these reference levels. A summary output reports whether any channel output is switched on, so software can tell that the timer is already in use.

Counting is controlled by a two-state machine: `HALT` and `RUN`.
- Transition *start*: a control write with bit 0 = 1 moves the machine to `RUN`.
- Transition *stop*: a control write with bit 0 = 0 moves it to `HALT`.
- No other input moves the state.

The divider and the counter advance only in `RUN`.

Top module: `tmr_trig_out`

Register map. Addresses are on `addr`. Data is `DATA_W` bits wide. Reads are combinational.

| Address | Contents |
|---|---|
| 0 | CTRL: bit 0 run, bit 1 reload buffering, bits 6:4 trigger select |
| 1 | DIV: divider value |
| 2 | TOP: terminal value |
| 3 | COUNT: counter value |
| 4 | EVENT: bit 0 forces an update; reads as 0 |
| 5 to 8 | CMP1 to CMP4: compare values |
| 9 | CHEN: bits 3:0 channel enables; bit 4 reads the summary flag |

## Requirements
- R1: After reset every register reads 0, the state is HALT, and `trgo` and `ch_active` are 0.
- R2: The counter changes only in RUN (CTRL bit 0), except when software writes it or forces an update. Writing COUNT (address 3) loads the written value, and COUNT reads it back.
- R3: In RUN the counter wraps from TOP to 0. This gives one wrap, or update event, every (DIV+1)*(TOP+1) clock cycles.
- R4: When CTRL bit 1 is 1, a TOP write is held until the next update event. When CTRL bit 1 is 0, a TOP write becomes the active terminal value at the same clock edge.
- R5: A DIV write takes effect only at the next update event. The divider count restarts from 0 on every update event.
- R6: Writing 1 to EVENT bit 0 forces an update at that clock edge. The counter becomes 0 and both pending values are loaded.
- R7: CTRL bits 6:4 select the source of `trgo`. `trgo` is registered one clock after its source.
  - 0: a pulse on forced updates only
  - 1: the run flag
  - 2: a pulse on every update event, whether wrap or forced
- R8: Select value 3 gives a one-cycle pulse in the same cycle that the counter steps onto the value in CMP1.
- R9: Select values 4 to 7 drive `trgo` from reference k = 1 to 4. Reference k is high while COUNT < CMPk, and the same levels appear on `oc_ref[3:0]`.
- R10: Take these steps in order:
  - write 0 to CTRL
  - write 0 to DIV
  - write 0 to TOP
  - force an update

  The counter then stays at 0, even when the timer is later restarted.
- R11: `ch_active` is 1 while any CHEN bit 3:0 is 1, and CHEN bit 4 reads the same flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| trgo | output | 1 | Selected trigger output |
| oc_ref | output | 4 | Compare reference levels |
| ch_active | output | 1 | Any channel output enabled |

## Verification
The properties assume that no more than one register access arrives per cycle, and that software writes COUNT only with values not above the active terminal value. The stimulus follows both rules. It applies every write through a single strobe that lasts one cycle, and it loads the counter only with small values below the programmed terminal value. The timing properties also assume that the selector does not change in the same cycle as the event being checked. The bench therefore programs the selector in its own write before it triggers any event.

// File: rtl/tmr_trig_pkg.sv
package tmr_trig_pkg;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_DIV   = 4'd1;
    localparam logic [ADDR_W-1:0] A_TOP   = 4'd2;
    localparam logic [ADDR_W-1:0] A_COUNT = 4'd3;
    localparam logic [ADDR_W-1:0] A_EVENT = 4'd4;
    localparam logic [ADDR_W-1:0] A_CMP1  = 4'd5;
    localparam logic [ADDR_W-1:0] A_CHEN  = 4'd9;

    localparam int CTRL_RUN = 0;
    localparam int CTRL_BUF = 1;
    localparam int SEL_LO   = 4;
    localparam int SEL_HI   = 6;

    typedef enum logic [2:0] {
        TS_FORCE, TS_ENABLE, TS_UPDATE, TS_CMP_PULSE,
        TS_REF1, TS_REF2, TS_REF3, TS_REF4
    } trig_sel_e;

    typedef enum logic {CS_HALT, CS_RUN} cnt_state_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         uev,
    input  logic [W-1:0] div_pre,
    output logic         tick,
    output logic [W-1:0] div_act,
    output logic [W-1:0] pcnt
);
    always_comb tick = run && (pcnt == div_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt    <= '0;
            div_act <= '0;
        end else if (uev) begin
            pcnt    <= '0;
            div_act <= div_pre;
        end else if (run) begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_trig_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_we,
    input  logic         run_wr,
    input  logic         tick,
    input  logic         force_upd,
    input  logic         cnt_we,
    input  logic         top_we,
    input  logic         buffered,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] top_pre,
    output logic         run,
    output logic         adv,
    output logic         ovf,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_adv
);
    cnt_state_e state_q;
    logic [W-1:0] top_act;

    // state register: start / stop transitions come from CTRL writes only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= CS_HALT;
        else if (ctrl_we) state_q <= run_wr ? CS_RUN : CS_HALT;
    end

    // outputs of the state machine
    always_comb begin
        unique case (state_q)
            CS_HALT: run = 1'b0;
            CS_RUN:  run = 1'b1;
        endcase
    end

    always_comb begin
        adv     = tick && !force_upd && !cnt_we;
        ovf     = adv && (cnt == top_act);
        cnt_adv = (cnt == top_act) ? '0 : cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            top_act <= '0;
        end else begin
            if (force_upd)   cnt <= '0;
            else if (cnt_we) cnt <= wr_data;
            else if (adv)    cnt <= cnt_adv;

            if (force_upd || ovf)      top_act <= top_pre;
            else if (top_we && !buffered) top_act <= wr_data;
        end
    end
endmodule

// File: rtl/tmr_trig_sel.sv
module tmr_trig_sel
    import tmr_trig_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  trig_sel_e           sel,
    input  logic                run,
    input  logic                adv,
    input  logic                force_upd,
    input  logic                ovf,
    input  logic [W-1:0]        cnt,
    input  logic [W-1:0]        cnt_adv,
    input  logic [N-1:0][W-1:0] cmp,
    output logic [N-1:0]        oc_ref,
    output logic                trgo
);
    logic hit;
    logic trgo_d;

    for (genvar g = 0; g < N; g++) begin : g_ref
        assign oc_ref[g] = cnt < cmp[g];
    end

    always_comb hit = adv && (cnt_adv == cmp[0]);

    always_comb begin
        unique case (sel)
            TS_FORCE:     trgo_d = force_upd;
            TS_ENABLE:    trgo_d = run;
            TS_UPDATE:    trgo_d = ovf || force_upd;
            TS_CMP_PULSE: trgo_d = hit;
            TS_REF1:      trgo_d = oc_ref[0];
            TS_REF2:      trgo_d = oc_ref[1];
            TS_REF3:      trgo_d = oc_ref[2];
            TS_REF4:      trgo_d = oc_ref[3];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trgo <= 1'b0;
        else        trgo <= trgo_d;
    end
endmodule

// File: rtl/tmr_trig_out.sv
module tmr_trig_out
    import tmr_trig_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              trgo,
    output logic [3:0]        oc_ref,
    output logic              ch_active
);
    localparam int CH_W = $clog2(NUM_CH);

    logic                          buffered_q;
    trig_sel_e                     sel_q;
    logic [DATA_W-1:0]             div_pre, top_pre;
    logic [NUM_CH-1:0][DATA_W-1:0] cmp_q;
    logic [NUM_CH-1:0]             chen_q;

    logic ctrl_we, force_upd, cnt_we, top_we;
    logic run, tick, adv, ovf;
    logic [DATA_W-1:0] cnt_q, cnt_adv, div_act, pcnt;
    logic [ADDR_W-1:0] cidx;

    always_comb begin
        ctrl_we   = wr_en && (addr == A_CTRL);
        top_we    = wr_en && (addr == A_TOP);
        cnt_we    = wr_en && (addr == A_COUNT);
        force_upd = wr_en && (addr == A_EVENT) && wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buffered_q <= 1'b0;
            sel_q      <= TS_FORCE;
            div_pre    <= '0;
            top_pre    <= '0;
            chen_q     <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL) begin
                buffered_q <= wdata[CTRL_BUF];
                sel_q      <= trig_sel_e'(wdata[SEL_HI:SEL_LO]);
            end
            if (addr == A_DIV)  div_pre <= wdata;
            if (addr == A_TOP)  top_pre <= wdata;
            if (addr == A_CHEN) chen_q  <= wdata[NUM_CH-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cmp_q[g] <= '0;
            else if (wr_en && addr == ADDR_W'(int'(A_CMP1) + g)) cmp_q[g] <= wdata;
        end
    end

    always_comb ch_active = |chen_q;
    always_comb cidx = addr - A_CMP1;

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CTRL_RUN]      = run;
                rdata[CTRL_BUF]      = buffered_q;
                rdata[SEL_HI:SEL_LO] = sel_q;
            end
            A_DIV:   rdata = div_pre;
            A_TOP:   rdata = top_pre;
            A_COUNT: rdata = cnt_q;
            A_CHEN: begin
                rdata[NUM_CH-1:0] = chen_q;
                rdata[NUM_CH]     = ch_active;
            end
            default: if (addr >= A_CMP1 && addr < A_CHEN) rdata = cmp_q[cidx[CH_W-1:0]];
        endcase
    end

    tmr_prescaler #(.W(DATA_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(run), .uev(ovf || force_upd),
        .div_pre(div_pre), .tick(tick), .div_act(div_act), .pcnt(pcnt)
    );

    tmr_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .run_wr(wdata[CTRL_RUN]),
        .tick(tick), .force_upd(force_upd), .cnt_we(cnt_we), .top_we(top_we),
        .buffered(buffered_q), .wr_data(wdata), .top_pre(top_pre),
        .run(run), .adv(adv), .ovf(ovf), .cnt(cnt_q), .cnt_adv(cnt_adv)
    );

    tmr_trig_sel #(.W(DATA_W), .N(NUM_CH)) u_sel (
        .clk(clk), .rst_n(rst_n), .sel(sel_q), .run(run), .adv(adv),
        .force_upd(force_upd), .ovf(ovf), .cnt(cnt_q), .cnt_adv(cnt_adv),
        .cmp(cmp_q), .oc_ref(oc_ref), .trgo(trgo)
    );
endmodule

// File: rtl/tmr_trig_out_chk.sv
module tmr_trig_out_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         reg_wr,
    input logic         force_upd,
    input logic         ovf,
    input logic [2:0]   mode,
    input logic         trgo,
    input logic [W-1:0] cnt,
    input logic [W-1:0] pcnt,
    input logic [W-1:0] div_act
);
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reg_wr) |=> $stable(cnt));

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == '0));

    p_div_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= div_act);

    p_force_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> (cnt == '0));

    p_update_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && (ovf || force_upd)) |=> trgo);

    p_force_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && !force_upd) |=> !trgo);
endmodule

bind tmr_trig_out tmr_trig_out_chk #(.W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .reg_wr(wr_en), .force_upd(force_upd),
    .ovf(ovf), .mode(sel_q), .trgo(trgo), .cnt(cnt_q), .pcnt(pcnt), .div_act(div_act)
);

// File: tb/tmr_trig_out_bench.sv
module tmr_trig_out_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int NV = 5;
    // divider, terminal value, expected update pulses in 60 cycles
    localparam logic [15:0] VEC [NV][3] = '{
        '{16'd0, 16'd3, 16'd15},
        '{16'd2, 16'd4, 16'd4},
        '{16'd1, 16'd1, 16'd15},
        '{16'd4, 16'd0, 16'd12},
        '{16'd3, 16'd2, 16'd5}
    };

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [W-1:0] wdata = '0, rdata;
    logic trgo, ch_active;
    logic [3:0] oc_ref;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_trig_out #(.DATA_W(W)) u_tmr_trig_out (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .trgo(trgo), .oc_ref(oc_ref), .ch_active(ch_active)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [W-1:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] v, v2;
        int hits, bad;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        rd(4'd0, v); chk("R1 ctrl", v, 0);
        rd(4'd3, v); chk("R1 count", v, 0);
        chk("R1 trgo", trgo, 0);
        chk("R1 ch_active", ch_active, 0);

        // R3 / R7 update-mode rate table
        for (int i = 0; i < NV; i++) begin
            wr(4'd0, 16'h0022);
            wr(4'd1, VEC[i][0]);
            wr(4'd2, VEC[i][1]);
            wr(4'd4, 16'h0001);
            wr(4'd0, 16'h0023);
            step(20);
            hits = 0;
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                if (trgo) hits++;
            end
            chk($sformatf("R3 R7 update pulses vector %0d", i), hits, VEC[i][2]);
        end

        // R4 buffered terminal value
        wr(4'd0, 16'h0002); wr(4'd1, 0); wr(4'd2, 9); wr(4'd4, 1);
        wr(4'd2, 3); wr(4'd3, 5); wr(4'd0, 16'h0003);
        step(4); rd(4'd3, v); chk("R4 buffered holds old top", v, 9);
        step(1); rd(4'd3, v); chk("R4 wrap at old top", v, 0);
        step(3); rd(4'd3, v); chk("R4 new top reached", v, 3);
        step(1); rd(4'd3, v); chk("R4 wrap at new top", v, 0);

        // R2 halt holds count, count write readback
        wr(4'd0, 16'h0002);
        rd(4'd3, v); step(5); rd(4'd3, v2); chk("R2 stable while halted", v2, v);
        wr(4'd3, 7); rd(4'd3, v); chk("R2 count write", v, 7);

        // R4 unbuffered immediate
        wr(4'd0, 16'h0000); wr(4'd2, 6); wr(4'd3, 5); wr(4'd0, 16'h0001);
        step(2); rd(4'd3, v); chk("R4 unbuffered immediate wrap", v, 0);

        // R5 divider deferred, R6 force
        wr(4'd0, 16'h0000); wr(4'd3, 0); wr(4'd1, 2); wr(4'd0, 16'h0001);
        step(1); rd(4'd3, v); chk("R5 divider not yet applied", v, 1);
        wr(4'd4, 1); rd(4'd3, v); chk("R6 force clears count", v, 0);
        step(2); rd(4'd3, v); chk("R5 divided hold", v, 0);
        step(1); rd(4'd3, v); chk("R5 divided step", v, 1);

        // R7 mode 0: no pulse on wraps, pulse on force
        wr(4'd0, 16'h0000); wr(4'd1, 0); wr(4'd2, 2); wr(4'd4, 1); wr(4'd0, 16'h0001);
        hits = 0;
        for (int c = 0; c < 8; c++) begin @(negedge clk); if (trgo) hits++; end
        chk("R7 mode0 quiet on wrap", hits, 0);
        wr(4'd4, 1); chk("R7 mode0 force pulse", trgo, 1);
        step(1); chk("R7 mode0 pulse ends", trgo, 0);

        // R7 mode 1 follows run
        wr(4'd0, 16'h0010); step(2); chk("R7 enable low", trgo, 0);
        wr(4'd0, 16'h0011); step(1); chk("R7 enable high", trgo, 1);

        // R8 compare pulse
        wr(4'd5, 3); wr(4'd0, 16'h0030); wr(4'd2, 9); wr(4'd4, 1); wr(4'd0, 16'h0031);
        hits = 0; bad = 0;
        addr = 4'd3;
        for (int c = 0; c < 24; c++) begin
            @(negedge clk); #1;
            if (trgo) hits++;
            if (trgo !== (rdata == 3)) bad++;
        end
        chk("R8 pulse count", hits, 3);
        chk("R8 pulse aligned with match", bad, 0);

        // R9 reference levels
        wr(4'd0, 16'h0040); wr(4'd3, 2); step(2);
        chk("R9 ref1 high", trgo, 1);
        wr(4'd3, 3); step(2); chk("R9 ref1 low", trgo, 0);
        wr(4'd8, 10); wr(4'd0, 16'h0070); step(2);
        chk("R9 ref4 high", trgo, 1);
        chk("R9 oc_ref levels", oc_ref, 4'b1000);

        // R10 stop sequence
        wr(4'd0, 16'h0021); wr(4'd2, 9); step(4);
        wr(4'd0, 0); wr(4'd1, 0); wr(4'd2, 0); wr(4'd4, 1);
        wr(4'd0, 16'h0001); step(5);
        rd(4'd3, v); chk("R10 count held at zero", v, 0);
        rd(4'd2, v); chk("R10 top zero", v, 0);
        rd(4'd1, v); chk("R10 div zero", v, 0);

        // R11 channel summary
        wr(4'd9, 16'h0004); chk("R11 active", ch_active, 1);
        rd(4'd9, v); chk("R11 readback", v, 16'h0014);
        wr(4'd9, 0); chk("R11 inactive", ch_active, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule